// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block keeps a small cache of logical-page to physical-page translations, each stored with a field of access-right bits. A logical address is divided into three fields. The low offset bits are never translated. The field just above the offset picks one set. The high bits form a tag. Every way of the chosen set compares its stored tag against the request tag at the same time. The way that matches selects the physical page number and rights that are returned. Entries that reach the buffer through the fill port replace entries in their set in least-recently-used order.

A lookup is a valid/ready request that carries a logical address. It is answered on a valid/ready response channel that has a single output register. A request is taken only while that register is empty, or is being emptied in the same cycle. While `resp_ready` is low, the response and `req_ready` stay frozen. The fill port is also valid/ready. It is refused only during a flush. A fill takes priority over a lookup, so `req_ready` is low in every cycle in which `fill_valid` is high. The `flush` input is a plain control pin. It invalidates every entry in one cycle and blocks both ports for that cycle. The table walk that produces fills lies outside this block.

Top module: `tlb_set_assoc`

## Requirements
- R1: On a hit, `resp_paddr[OFF_W-1:0]` equals the request's offset bits `req_vaddr[OFF_W-1:0]` unchanged.
- R2: A lookup hits when a valid entry in set `req_vaddr[OFF_W+IDX_W-1:OFF_W]` holds tag `req_vaddr[VA_W-1:OFF_W+IDX_W]`. The response then has `resp_hit`=1, `resp_paddr`={stored page, offset} and `resp_rights`=stored rights. Fills into other sets leave the entry untouched.
- R3: On a miss, `resp_hit`=0, `resp_paddr`=0 and `resp_rights`=0.
- R4: With two ways, two pages that share a set index but have different tags stay resident together. Lookups that alternate between them all hit.
- R5: A fill into a set whose ways are all valid replaces the least recently used way. Both a lookup hit and a fill make the touched way the most recently used.
- R6: A fill into a set that still has an invalid way writes the lowest-numbered invalid way and evicts no valid entry.
- R7: A fill whose tag is already resident in its set overwrites that way and no other.
- R8: A cycle with `flush` high invalidates every entry, so all lookups after it miss. `fill_ready` is low during that cycle.
- R9: `req_ready` = !`flush` && !`fill_valid` && (!`resp_valid` || `resp_ready`). The response to an accepted request is valid in the cycle after acceptance. Without a new request, `resp_valid` drops after a cycle with `resp_ready` high.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_hit`, `resp_paddr` and `resp_rights` hold their values.
- R11: After reset, `resp_valid` is 0, `req_ready` and `fill_ready` are 1, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | VA_W | Logical address to translate |
| resp_valid | output | 1 | Lookup result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_hit | output | 1 | Translation found |
| resp_paddr | output | PPN_W+OFF_W | Physical address, zero on a miss |
| resp_rights | output | RT_W | Access rights, zero on a miss |
| fill_valid | input | 1 | New translation offered |
| fill_ready | output | 1 | New translation can be installed |
| fill_vpn | input | VA_W-OFF_W | Logical page number (tag and set index) of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_rights | input | RT_W | Access rights of the fill |
| flush | input | 1 | Invalidate all entries this cycle |

## Verification
A lookup result is due exactly one clock edge after the edge that accepts the request. The bench drives each request at a falling edge, waits for the rising edge that accepts it, and samples the response one time step after that edge. A fill or flush takes effect at the edge where it is presented, so the next lookup, one cycle later, already sees it. Ready signals are sampled shortly after the falling edge, once the inputs for that cycle are settled. The back-pressure check holds `resp_ready` low for three edges and samples after each one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Reason a fill chose its target way
  typedef enum logic [1:0] {
    PICK_MATCH = 2'd0,
    PICK_FREE  = 2'd1,
    PICK_LRU   = 2'd2
  } victim_src_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  parameter int PPN_W = 8,
  parameter int RT_W  = 4,
  localparam int SET_W = idx_width(SETS),
  localparam int WAY_W = idx_width(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  // lookup side
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [RT_W-1:0]  hit_rights,
  // fill side
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [RT_W-1:0]  wr_rights,
  output logic [WAYS-1:0]  wr_valid_vec,
  output logic [WAYS-1:0]  wr_match_vec
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  logic [RT_W-1:0]  rt_q    [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      ppn_q[wr_set][wr_way] <= wr_ppn;
      rt_q[wr_set][wr_way]  <= wr_rights;
    end
  end

  // Parallel tag compare for every way of both addressed sets
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w]      = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    assign wr_valid_vec[w] = valid_q[wr_set][w];
    assign wr_match_vec[w] = valid_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag);
  end

  // AND-OR multiplexer driven by the hit vector
  always_comb begin
    hit_ppn    = '0;
    hit_rights = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_ppn    = hit_ppn | ppn_q[rd_set][w];
        hit_rights = hit_rights | rt_q[rd_set][w];
      end
    end
  end

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !any_valid); // R8

endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int SET_W = idx_width(SETS),
  localparam int WAY_W = idx_width(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] lru_way
);

  // Each way of a set holds a distinct age; 0 = most recent, WAYS-1 = oldest
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set][w] == AGE_W'(WAYS - 1)) lru_way = WAY_W'(w);
  end

  // checker state
  int unsigned oldest_cnt;
  always_comb begin
    oldest_cnt = 0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set][w] == AGE_W'(WAYS - 1)) oldest_cnt++;
  end

  logic             chk_touch_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_touch_q <= 1'b0;
      chk_set_q   <= '0;
      chk_way_q   <= '0;
    end else begin
      chk_touch_q <= touch_en;
      chk_set_q   <= touch_set;
      chk_way_q   <= touch_way;
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_cnt == 1); // R5

  AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    chk_touch_q |-> age_q[chk_set_q][chk_way_q] == '0); // R5

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
  import tlb_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = idx_width(WAYS)
) (
  input  logic [WAYS-1:0]  match_vec,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] pick_way,
  output victim_src_e      pick_src
);

  logic [WAY_W-1:0] match_way;
  logic [WAY_W-1:0] free_way;

  // Scan from the top so the lowest-numbered candidate wins
  always_comb begin
    match_way = '0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) match_way = WAY_W'(w);
      if (!valid_vec[w]) free_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (|match_vec) begin
      pick_way = match_way;
      pick_src = PICK_MATCH;
    end else if (!(&valid_vec)) begin
      pick_way = free_way;
      pick_src = PICK_FREE;
    end else begin
      pick_way = lru_way;
      pick_src = PICK_LRU;
    end
  end

endmodule

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc
  import tlb_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int IDX_W = 4,
  parameter int WAYS  = 2,
  parameter int PPN_W = 8,
  parameter int RT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   resp_valid,
  input  logic                   resp_ready,
  output logic                   resp_hit,
  output logic [PPN_W+OFF_W-1:0] resp_paddr,
  output logic [RT_W-1:0]        resp_rights,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [RT_W-1:0]        fill_rights,
  input  logic                   flush
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = idx_width(WAYS);
  localparam int PA_W  = PPN_W + OFF_W;

  // ---------------- handshakes ----------------
  logic resp_valid_q;
  logic req_fire;
  logic fill_fire;

  assign fill_ready = !flush;
  assign fill_fire  = fill_valid && !flush;
  assign req_ready  = !flush && !fill_valid && (!resp_valid_q || resp_ready);
  assign req_fire   = req_valid && req_ready;

  // ---------------- address fields ----------------
  logic [IDX_W-1:0] rd_set;
  logic [TAG_W-1:0] rd_tag;
  logic [OFF_W-1:0] rd_off;
  logic [IDX_W-1:0] wr_set;
  logic [TAG_W-1:0] wr_tag;

  assign rd_off = req_vaddr[OFF_W-1:0];
  assign rd_set = req_vaddr[OFF_W +: IDX_W];
  assign rd_tag = req_vaddr[VA_W-1 -: TAG_W];
  assign wr_set = fill_vpn[IDX_W-1:0];
  assign wr_tag = fill_vpn[VPN_W-1 -: TAG_W];

  // ---------------- storage ----------------
  logic [WAYS-1:0]  hit_vec;
  logic [PPN_W-1:0] hit_ppn;
  logic [RT_W-1:0]  hit_rights;
  logic [WAYS-1:0]  wr_valid_vec;
  logic [WAYS-1:0]  wr_match_vec;
  logic [WAY_W-1:0] pick_way;
  victim_src_e      pick_src;
  logic [WAY_W-1:0] lru_way;

  tlb_entry_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .RT_W(RT_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .rd_set       (rd_set),
    .rd_tag       (rd_tag),
    .hit_vec      (hit_vec),
    .hit_ppn      (hit_ppn),
    .hit_rights   (hit_rights),
    .wr_en        (fill_fire),
    .wr_set       (wr_set),
    .wr_tag       (wr_tag),
    .wr_way       (pick_way),
    .wr_ppn       (fill_ppn),
    .wr_rights    (fill_rights),
    .wr_valid_vec (wr_valid_vec),
    .wr_match_vec (wr_match_vec)
  );

  // ---------------- replacement ----------------
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic             touch_en;
  logic [IDX_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign touch_en  = fill_fire || (req_fire && hit_any);
  assign touch_set = fill_fire ? wr_set : rd_set;
  assign touch_way = fill_fire ? pick_way : hit_way;

  tlb_age_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .query_set (wr_set),
    .lru_way   (lru_way)
  );

  tlb_victim_pick #(.WAYS(WAYS)) u_pick (
    .match_vec (wr_match_vec),
    .valid_vec (wr_valid_vec),
    .lru_way   (lru_way),
    .pick_way  (pick_way),
    .pick_src  (pick_src)
  );

  // ---------------- response register ----------------
  logic            resp_hit_q;
  logic [PA_W-1:0] resp_paddr_q;
  logic [RT_W-1:0] resp_rights_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_q  <= 1'b0;
      resp_hit_q    <= 1'b0;
      resp_paddr_q  <= '0;
      resp_rights_q <= '0;
    end else if (req_fire) begin
      resp_valid_q  <= 1'b1;
      resp_hit_q    <= hit_any;
      resp_paddr_q  <= hit_any ? {hit_ppn, rd_off} : '0;
      resp_rights_q <= hit_any ? hit_rights : '0;
    end else if (resp_ready) begin
      resp_valid_q  <= 1'b0;
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_hit    = resp_hit_q;
  assign resp_paddr  = resp_paddr_q;
  assign resp_rights = resp_rights_q;

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid); // R9

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit)
      && $stable(resp_paddr) && $stable(resp_rights))); // R10

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_paddr == '0 && resp_rights == '0)); // R3

endmodule

// File: tb/tlb_set_assoc_bench.sv
module tlb_set_assoc_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_vaddr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_hit;
  logic [15:0] resp_paddr;
  logic [3:0]  resp_rights;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [7:0]  fill_vpn = '0;
  logic [7:0]  fill_ppn = '0;
  logic [3:0]  fill_rights = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_set_assoc u_tlb_set_assoc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_paddr(resp_paddr), .resp_rights(resp_rights),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rights(fill_rights), .flush(flush)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Ops: 0 lookup, 1 fill, 2 flush
  // Fields: req[54:51] op[50:49] addr[48:33] ppn[32:25] rt[24:21]
  //         hit[20] paddr[19:4] rights[3:0]
  localparam int NV = 25;
  localparam logic [54:0] VEC [NV] = '{
    {4'd11, 2'd0, 16'h35E6, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R11 empty
    {4'd0,  2'd1, 16'h3500, 8'hA1, 4'h3, 1'b0, 16'h0000, 4'h0},
    {4'd0,  2'd1, 16'h5500, 8'hB2, 4'h5, 1'b0, 16'h0000, 4'h0},
    {4'd2,  2'd0, 16'h35E6, 8'h00, 4'h0, 1'b1, 16'hA1E6, 4'h3}, // R2
    {4'd4,  2'd0, 16'h5537, 8'h00, 4'h0, 1'b1, 16'hB237, 4'h5}, // R4
    {4'd4,  2'd0, 16'h35E6, 8'h00, 4'h0, 1'b1, 16'hA1E6, 4'h3}, // R4
    {4'd0,  2'd1, 16'h7500, 8'hC3, 4'h6, 1'b0, 16'h0000, 4'h0},
    {4'd5,  2'd0, 16'h5537, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R5 evicted
    {4'd5,  2'd0, 16'h3500, 8'h00, 4'h0, 1'b1, 16'hA100, 4'h3}, // R5 kept
    {4'd5,  2'd0, 16'h7512, 8'h00, 4'h0, 1'b1, 16'hC312, 4'h6}, // R5 new
    {4'd1,  2'd0, 16'h35FF, 8'h00, 4'h0, 1'b1, 16'hA1FF, 4'h3}, // R1
    {4'd0,  2'd1, 16'h3500, 8'hD4, 4'h7, 1'b0, 16'h0000, 4'h0},
    {4'd7,  2'd0, 16'h7512, 8'h00, 4'h0, 1'b1, 16'hC312, 4'h6}, // R7
    {4'd7,  2'd0, 16'h3534, 8'h00, 4'h0, 1'b1, 16'hD434, 4'h7}, // R7
    {4'd0,  2'd1, 16'h3A00, 8'h11, 4'h1, 1'b0, 16'h0000, 4'h0},
    {4'd2,  2'd0, 16'h3A80, 8'h00, 4'h0, 1'b1, 16'h1180, 4'h1}, // R2
    {4'd3,  2'd0, 16'h3980, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R3
    {4'd2,  2'd0, 16'h3534, 8'h00, 4'h0, 1'b1, 16'hD434, 4'h7}, // R2
    {4'd8,  2'd2, 16'h0000, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R8 flush
    {4'd8,  2'd0, 16'h3534, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R8
    {4'd8,  2'd0, 16'h3A80, 8'h00, 4'h0, 1'b0, 16'h0000, 4'h0}, // R8
    {4'd0,  2'd1, 16'h9500, 8'hEE, 4'hF, 1'b0, 16'h0000, 4'h0},
    {4'd0,  2'd1, 16'hA500, 8'h6F, 4'h2, 1'b0, 16'h0000, 4'h0},
    {4'd6,  2'd0, 16'h9501, 8'h00, 4'h0, 1'b1, 16'hEE01, 4'hF}, // R6
    {4'd6,  2'd0, 16'hA5FE, 8'h00, 4'h0, 1'b1, 16'h6FFE, 4'h2}  // R6
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R11", "resp_valid after reset", 32'(resp_valid), 32'd0);
    chk("R11", "req_ready after reset", 32'(req_ready), 32'd1);
    chk("R11", "fill_ready after reset", 32'(fill_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[54:51]);
      @(negedge clk);
      case (v[50:49])
        2'd0: begin
          req_valid = 1'b1;
          req_vaddr = v[48:33];
          #1 chk("R9", "req_ready idle", 32'(req_ready), 32'd1);
          @(posedge clk); #1;
          req_valid = 1'b0;
          chk("R9", "resp_valid one cycle later", 32'(resp_valid), 32'd1);
          chk(rq, $sformatf("hit vec %0d", i), 32'(resp_hit), 32'(v[20]));
          chk(rq, $sformatf("paddr vec %0d", i), 32'(resp_paddr), 32'(v[19:4]));
          chk(rq, $sformatf("rights vec %0d", i), 32'(resp_rights), 32'(v[3:0]));
        end
        2'd1: begin
          fill_valid  = 1'b1;
          fill_vpn    = v[48:41];
          fill_ppn    = v[32:25];
          fill_rights = v[24:21];
          #1 chk("R9", "req_ready low during fill", 32'(req_ready), 32'd0);
          @(posedge clk); #1;
          fill_valid = 1'b0;
        end
        default: begin
          flush = 1'b1;
          #1 chk("R8", "fill_ready low during flush", 32'(fill_ready), 32'd0);
          @(posedge clk); #1;
          flush = 1'b0;
        end
      endcase
    end

    // response drops when nothing new is accepted
    @(posedge clk); #1;
    chk("R9", "resp_valid drops", 32'(resp_valid), 32'd0);

    // back-pressure on the response channel
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 8'h12; fill_ppn = 8'h34; fill_rights = 4'h9;
    @(posedge clk); #1 fill_valid = 1'b0;
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 16'h12AB;
    @(posedge clk); #1;
    req_vaddr = 16'h0000;
    chk("R10", "held resp valid", 32'(resp_valid), 32'd1);
    chk("R10", "held paddr", 32'(resp_paddr), 32'h34AB);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R9", "req_ready low while stalled", 32'(req_ready), 32'd0);
      @(posedge clk); #1;
      chk("R10", "paddr stable under stall", 32'(resp_paddr), 32'h34AB);
      chk("R10", "rights stable under stall", 32'(resp_rights), 32'h9);
      chk("R10", "valid stable under stall", 32'(resp_valid), 32'd1);
    end
    @(negedge clk) resp_ready = 1'b1;
    #1 chk("R9", "req_ready returns with resp_ready", 32'(req_ready), 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R3", "miss paddr after stall", 32'(resp_paddr), 32'h0);
    chk("R3", "miss hit flag after stall", 32'(resp_hit), 32'd0);
    @(posedge clk); #1;
    chk("R9", "resp_valid clears", 32'(resp_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule